// File: doc/BRIEF.md
# Variable Pulse Fault Injector

This block sits in series with a digital signal line, between its driver and its receiver. Most of the time it passes the line through unchanged. When enabled, it runs a pulse train whose high time and repetition interval can both be set at run time. While a pulse is high, a 2:1 output multiplexer drops the original value and drives a faulty one instead, which imitates a burst of interference on that wire.

The faulty value is either a fixed stuck level or the inverse of the incoming value. An optional random gate uses a free-running 16-bit LFSR. It decides once at the start of each repetition interval whether that interval's pulse is applied at all, so each pulse can be made to occur only with a set probability.

A one-cycle trigger marks the start of every applied pulse. Wiring it to the restart input of a further injector makes several lines fail together as a cluster.

Top module: `pulse_fault_injector`

## Requirements
- R1: While `rstN` is low, `dataOut` equals `dataIn` and `chainOut` is 0, whatever the other inputs are.
- R2: While `enable` is low, the interval counter is cleared and `dataOut` equals `dataIn`. In the first cycle after a clock edge that sees `enable` high following a cleared counter, the counter reads 1.
- R3: With `enable` high, the counter advances 1, 2, …, `periodCfg` and then returns to 1. A `periodCfg` of 0 or 1 gives a counter that reads 1 every cycle.
- R4: The line is corrupted in the cycles whose count is between 1 and `widthCfg`. A `widthCfg` of 0 never corrupts the line. A `widthCfg` at or above `periodCfg` corrupts it in every enabled cycle.
- R5: During a pulse, `dataOut` is `stuckLevel` when `modeInvert` is 0 and `~dataIn` when `modeInvert` is 1. Outside a pulse it is exactly `dataIn`.
- R6: `chainOut` is high for exactly one cycle, the count-1 cycle, of each interval whose pulse is applied and whose `widthCfg` is at least 1. It is low at all other times.
- R7: A clock edge that sees both `enable` and `chainIn` high restarts the counter, so that it reads 1 in the following cycle.
- R8: The apply decision is taken at each edge that restarts the interval and holds for the whole interval. With `useRandom` 0 the pulse is always applied. With `useRandom` 1 it is applied only if the LFSR value is below `threshold`, so a `threshold` of 0 never applies it and a mid-range value applies some intervals and skips others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the pulse generator; low clears it |
| widthCfg | input | CNT_W | Pulse high time in cycles |
| periodCfg | input | CNT_W | Repetition interval in cycles |
| modeInvert | input | 1 | 0: drive stuck level, 1: drive inverted line |
| stuckLevel | input | DATA_W | Level driven in stuck mode |
| useRandom | input | 1 | Turns on the probabilistic gate |
| threshold | input | 16 | Gate threshold compared with the LFSR |
| chainIn | input | 1 | Restart trigger from an upstream injector |
| dataIn | input | DATA_W | Original signal line |
| dataOut | output | DATA_W | Protected, possibly corrupted line |
| chainOut | output | 1 | One-cycle trigger at the start of each applied pulse |

## Verification
The properties assume that the configuration inputs change only between clock edges. The chain assertion further assumes that a count-1 cycle with an interval longer than one is followed by a count-2 cycle, which holds only if no restart arrives in between. The bench drives every input on the falling edge and keeps each configuration fixed across a segment. Where it changes width, interval or mode, it does so at segment boundaries and lets its own reference model follow the change. The random segment uses the inverting mode, so every applied pulse is visible on the line. It checks each interval as all-or-nothing and does not predict the LFSR.

// File: rtl/finj_pkg.sv
package finj_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  // strobes from control to datapath
  typedef struct packed {
    logic pulseOn;
    logic chainStart;
  } finj_strobe_t;
endpackage

// File: rtl/finj_lfsr.sv
module finj_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = '1,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rstN,
  output logic [W-1:0] state
);
  logic [W-1:0] nextState;

  // Galois form, shifting right
  always_comb begin
    nextState = state >> 1;
    if (state[0]) nextState = nextState ^ TAPS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEED;
    else       state <= nextState;
  end
endmodule

// File: rtl/finj_ctrl.sv
module finj_ctrl
  import finj_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              chainIn,
  input  logic [CNT_W-1:0]  widthCfg,
  input  logic [CNT_W-1:0]  periodCfg,
  input  logic              useRandom,
  input  logic [LFSR_W-1:0] threshold,
  input  logic [LFSR_W-1:0] lfsrVal,
  output finj_strobe_t      strobe,
  output logic [CNT_W-1:0]  periodCnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic allowPulse;
  logic wrapNow;
  logic gateOpen;
  logic inWindow;

  always_comb begin
    wrapNow  = (periodCnt == '0) || (periodCnt >= periodCfg) || chainIn;
    gateOpen = !useRandom || (lfsrVal < threshold);
    inWindow = (periodCnt != '0) && (periodCnt <= widthCfg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt  <= '0;
      allowPulse <= 1'b0;
    end else if (!enable) begin
      periodCnt  <= '0;
      allowPulse <= 1'b0;
    end else if (wrapNow) begin
      periodCnt  <= ONE;
      allowPulse <= gateOpen;
    end else begin
      periodCnt  <= periodCnt + ONE;
    end
  end

  always_comb begin
    strobe.pulseOn    = allowPulse && inWindow;
    strobe.chainStart = allowPulse && inWindow && (periodCnt == ONE);
  end
endmodule

// File: rtl/finj_dpath.sv
module finj_dpath
  import finj_pkg::*;
#(
  parameter int DATA_W = 1
) (
  input  finj_strobe_t       strobe,
  input  logic               modeInvert,
  input  logic [DATA_W-1:0]  stuckLevel,
  input  logic [DATA_W-1:0]  dataIn,
  output logic [DATA_W-1:0]  dataOut,
  output logic               chainOut
);
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_lane
      logic faultBit;
      always_comb begin
        faultBit    = modeInvert ? ~dataIn[gi] : stuckLevel[gi];
        dataOut[gi] = strobe.pulseOn ? faultBit : dataIn[gi];
      end
    end
  endgenerate

  assign chainOut = strobe.chainStart;
endmodule

// File: rtl/pulse_fault_injector.sv
module pulse_fault_injector
  import finj_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CNT_W-1:0]  widthCfg,
  input  logic [CNT_W-1:0]  periodCfg,
  input  logic              modeInvert,
  input  logic [DATA_W-1:0] stuckLevel,
  input  logic              useRandom,
  input  logic [LFSR_W-1:0] threshold,
  input  logic              chainIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              chainOut
);
  logic [LFSR_W-1:0] lfsrVal;
  logic [CNT_W-1:0]  periodCnt;
  finj_strobe_t      strobe;

  finj_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rstN(rstN), .state(lfsrVal)
  );

  finj_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .chainIn(chainIn),
    .widthCfg(widthCfg), .periodCfg(periodCfg), .useRandom(useRandom),
    .threshold(threshold), .lfsrVal(lfsrVal), .strobe(strobe),
    .periodCnt(periodCnt)
  );

  finj_dpath #(.DATA_W(DATA_W)) u_dpath (
    .strobe(strobe), .modeInvert(modeInvert), .stuckLevel(stuckLevel),
    .dataIn(dataIn), .dataOut(dataOut), .chainOut(chainOut)
  );
endmodule

// File: rtl/finj_checker.sv
module finj_checker #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              chainIn,
  input logic [CNT_W-1:0]  widthCfg,
  input logic [CNT_W-1:0]  periodCfg,
  input logic              useRandom,
  input logic [15:0]       threshold,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] dataOut,
  input logic              chainOut,
  input logic [CNT_W-1:0]  periodCnt
);
  // R2: a generator disabled at the last edge leaves the line untouched
  a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> (dataOut == dataIn) && !chainOut);

  // R4: zero width never corrupts
  a_r4_zero_width: assert property (@(posedge clk) disable iff (!rstN)
    (widthCfg == '0) |-> (dataOut == dataIn) && !chainOut);

  // R6: the trigger lasts one cycle when the interval is longer than one
  a_r6_chain_single: assert property (@(posedge clk) disable iff (!rstN)
    chainOut && enable && !chainIn && (periodCfg > CNT_W'(1)) |=> !chainOut);

  // R7: an upstream trigger restarts the interval
  a_r7_chain_restart: assert property (@(posedge clk) disable iff (!rstN)
    enable && chainIn |=> (periodCnt == CNT_W'(1)));

  // R8: with a zero threshold at the start edge the interval stays clean
  a_r8_gate_closed: assert property (@(posedge clk) disable iff (!rstN)
    (periodCnt == CNT_W'(1)) && $past(useRandom) && ($past(threshold) == 16'd0)
    |-> (dataOut == dataIn) && !chainOut);
endmodule

bind pulse_fault_injector finj_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .chainIn(chainIn),
  .widthCfg(widthCfg), .periodCfg(periodCfg), .useRandom(useRandom),
  .threshold(threshold), .dataIn(dataIn), .dataOut(dataOut),
  .chainOut(chainOut), .periodCnt(periodCnt)
);

// File: tb/sim_pulse_fault_injector.sv
`timescale 1ns/1ps
module sim_pulse_fault_injector;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  widthCfg = '0;
  logic [7:0]  periodCfg = '0;
  logic        modeInvert = 1'b0;
  logic [0:0]  stuckLevel = '0;
  logic        useRandom = 1'b0;
  logic [15:0] threshold = '0;
  logic        chainIn = 1'b0;
  logic [0:0]  dataIn = '0;
  logic [0:0]  dataOut;
  logic        chainOut;

  always #10 clk = ~clk;

  pulse_fault_injector #(.CNT_W(8), .DATA_W(1)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .widthCfg(widthCfg),
    .periodCfg(periodCfg), .modeInvert(modeInvert), .stuckLevel(stuckLevel),
    .useRandom(useRandom), .threshold(threshold), .chainIn(chainIn),
    .dataIn(dataIn), .dataOut(dataOut), .chainOut(chainOut)
  );

  typedef struct {
    string tag;
    bit    rnd;
    int    cnt;
    int    width;
    logic  din;
    logic  expOut;
    logic  expChain;
  } item_t;

  item_t q[$];
  int errors = 0;
  int checks = 0;
  int applied = 0;
  int skipped = 0;
  bit done = 0;

  // reference model state and inputs applied for the coming edge
  int mCnt = 0;
  bit mAllow = 0;
  bit mUnk = 0;
  bit aRstN = 0, aEn = 0, aCh = 0, aUr = 0;
  int aPer = 0, aThr = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit rst, bit en, bit ch, int w, int p,
                      bit md, bit stk, bit ur, int thr);
    item_t it;
    bit pulse;
    @(negedge clk);
    // advance the model over the edge just passed
    if (!aRstN || !aEn) begin
      mCnt = 0; mAllow = 0; mUnk = 0;
    end else if (mCnt == 0 || mCnt >= aPer || aCh) begin
      mCnt = 1;
      if (!aUr) begin mAllow = 1; mUnk = 0; end
      else if (aThr == 0) begin mAllow = 0; mUnk = 0; end
      else mUnk = 1;
    end else begin
      mCnt++;
    end
    rstN = rst; enable = en; chainIn = ch;
    widthCfg = 8'(w); periodCfg = 8'(p); modeInvert = md;
    stuckLevel = stk; useRandom = ur; threshold = 16'(thr);
    dataIn = 1'($urandom_range(1, 0));
    aRstN = rst; aEn = en; aCh = ch; aPer = p; aUr = ur; aThr = thr;
    if (!rst) begin mCnt = 0; mAllow = 0; mUnk = 0; end
    pulse = mAllow && !mUnk && mCnt != 0 && mCnt <= w;
    it.tag = tag; it.rnd = mUnk; it.cnt = mCnt; it.width = w;
    it.din = dataIn[0];
    it.expOut = pulse ? (md ? ~dataIn[0] : stk) : dataIn[0];
    it.expChain = pulse && (mCnt == 1);
    q.push_back(it);
  endtask

  // monitor: pops one expected item per cycle and compares
  initial begin
    item_t it;
    bit hit = 0;
    bit corrupt;
    forever begin
      @(negedge clk);
      #4;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (!it.rnd) begin
          check(dataOut[0] === it.expOut, it.tag, "dataOut", int'(dataOut[0]), int'(it.expOut));
          check(chainOut === it.expChain, it.tag, "chainOut", int'(chainOut), int'(it.expChain));
        end else begin
          corrupt = (dataOut[0] !== it.din);
          if (it.cnt == 0 || it.cnt > it.width) begin
            check(!corrupt, it.tag, "outside window corrupted", int'(corrupt), 0);
            check(!chainOut, it.tag, "chainOut outside start", int'(chainOut), 0);
          end else if (it.cnt == 1) begin
            hit = corrupt;
            if (corrupt) applied++; else skipped++;
            check(chainOut === corrupt, it.tag, "chainOut at start", int'(chainOut), int'(corrupt));
          end else begin
            check(corrupt == hit, it.tag, "decision held in interval", int'(corrupt), int'(hit));
            check(!chainOut, it.tag, "chainOut after start", int'(chainOut), 0);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: config ignored during reset
    for (int i = 0; i < 6; i++) step("R1", 0, 1, 1, 3, 8, 0, 1, 0, 0);
    // R2: disabled passes through
    for (int i = 0; i < 8; i++) step("R2", 1, 0, 0, 3, 8, 0, 1, 0, 0);
    // R3 / R4: stuck-high pulses, width 3 in an interval of 8
    for (int i = 0; i < 24; i++) step("R4", 1, 1, 0, 3, 8, 0, 1, 0, 0);
    // R2: drop enable mid-interval, then re-enable
    for (int i = 0; i < 3; i++) step("R2", 1, 0, 0, 3, 8, 0, 1, 0, 0);
    // R5: invert mode, width 2 interval 5
    for (int i = 0; i < 20; i++) step("R5", 1, 1, 0, 2, 5, 1, 0, 0, 0);
    // R5: stuck-low mode
    for (int i = 0; i < 15; i++) step("R5", 1, 1, 0, 2, 5, 0, 0, 0, 0);
    // R4: zero width
    for (int i = 0; i < 16; i++) step("R4", 1, 1, 0, 0, 6, 1, 0, 0, 0);
    // R6: width beyond interval, continuous pulse, trigger every 6
    for (int i = 0; i < 24; i++) step("R6", 1, 1, 0, 10, 6, 1, 0, 0, 0);
    // R3: interval 0 and 1
    for (int i = 0; i < 8; i++) step("R3", 1, 1, 0, 1, 0, 1, 0, 0, 0);
    for (int i = 0; i < 8; i++) step("R3", 1, 1, 0, 1, 1, 0, 1, 0, 0);
    // R7: upstream restarts
    for (int i = 0; i < 40; i++) step("R7", 1, 1, (i % 7) == 6, 2, 10, 1, 0, 0, 0);
    // R8: gate closed, then gate off with zero threshold
    for (int i = 0; i < 20; i++) step("R8", 1, 1, 0, 3, 6, 1, 0, 1, 0);
    for (int i = 0; i < 20; i++) step("R8", 1, 1, 0, 3, 6, 1, 0, 0, 0);
    // R8: half-probability gate
    for (int i = 0; i < 900; i++) step("R8", 1, 1, 0, 3, 6, 1, 0, 1, 16'h8000);
    repeat (3) @(negedge clk);
    check(applied > 0, "R8", "applied intervals", applied, 1);
    check(skipped > 0, "R8", "skipped intervals", skipped, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule